// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block sits between a bank of interrupt request pins and the system interconnect. For each pin it reads a 64-bit redirection entry from a separate register file. It uses that entry to decide when the pin's interrupt goes out, and it turns each delivery into a 32-bit address/data message on a valid/ready stream. Edge-triggered pins latch a pending bit on each rising edge. Level-triggered pins follow their input and are coalesced through a remote-IRR bit that lives in the register file. The block raises per-pin strobes to set or clear that bit.

Deliveries happen in service passes. A pass walks the pins from the lowest index upward and sends at most one message per cycle. It waits whenever the stream is not ready. A new request that arrives while a pass is running causes a second pass once the first one ends. An end-of-interrupt notification carries a vector. It releases every level pin that is waiting on that vector, and it starts a pass when such a pin still has a request pending.

The register file is expected to apply a set or clear strobe at the same clock edge at which the strobe is high. The updated entry is then visible on the entry bus in the next cycle.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset, msgValid is low and no remote-IRR set or clear strobe is raised until a request or an end-of-interrupt arrives.
- R2: A rising edge on an unmasked edge-triggered pin (entry bit 15 = 0, mask bit 16 = 0) produces exactly one message. The pin's pending bit is cleared when it is serviced, so no further message follows.
- R3: Message address = 0xFEE00000 OR (entry bits 63:48 shifted left by 12) OR (entry bit 11 shifted left by 2). Message data = entry bits 7:0 in bits 7:0, entry bits 10:8 in bits 10:8, entry bit 15 in bit 15, and zero in all other bits.
- R4: Request input 0 drives pin 2 and is delivered using entry 2. Every other input k drives pin k. Pin 0 has no source and never delivers.
- R5: A rising edge on a masked edge-triggered pin is discarded. Unmasking the pin later and running a pass sends nothing for it.
- R6: A pass visits pins in ascending index order. A pin whose entry is masked when the pass reaches it is skipped and keeps its pending bit, so a later pass delivers it once it is unmasked.
- R7: Servicing an unmasked level-triggered pin (bit 15 = 1) whose remote-IRR bit (bit 14) is clear sends one message and pulses that pin's set strobe. While remote-IRR is set, further assertions of the pin send nothing.
- R8: An end-of-interrupt with vector V pulses the clear strobe of every entry that has remote-IRR set and vector field (bits 7:0) equal to V. If such an entry is unmasked and its input is still high, a pass starts and the pin is delivered again. A non-matching vector has no effect.
- R9: A level pin's pending state follows its input. If the input has dropped before the end-of-interrupt, remote-IRR is cleared and no message is sent. A later assertion with remote-IRR clear is delivered.
- R10: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData hold their values, and the pass stalls.
- R11: Several pins asserted in the same cycle are delivered as one message each, in ascending pin order.
- R12: A request that arrives during a pass, on a pin below the pass's current position, is delivered by a follow-up pass after the running pass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_PINS | Interrupt request inputs, active high |
| rteIn | input | NUM_PINS*64 | Redirection entries; entry p occupies bits p*64+63 : p*64 |
| eoiValid | input | 1 | End-of-interrupt notification strobe |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| msgValid | output | 1 | Message valid |
| msgReady | input | 1 | Message accepted by the consumer |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |
| rirrSet | output | NUM_PINS | Per-entry strobe that sets remote-IRR |
| rirrClr | output | NUM_PINS | Per-entry strobe that clears remote-IRR |

## Verification
Two functions of this block can act in the same cycle: the scan of a running pass, and the arrival of a new request or of a change to an entry. The bench holds msgReady low so that a pass stalls partway through the pins. While it is stalled, the bench raises a pin below the scan position, or it masks a pin that the scan has not yet reached. It then releases the stream. The result is judged on the order and content of the messages that follow: the pin below the scan position must appear only after the stalled pass's remaining pins, and a pin masked during the stall must be missing until it is unmasked and a later pass runs.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;

  localparam int ENTRY_W   = 64;
  localparam int DM_LSB    = 8;
  localparam int DMODE_BIT = 11;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 48;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

  typedef struct packed {
    logic [7:0]  vector;
    logic [2:0]  dlvMode;
    logic        dstMode;
    logic        remoteIrr;
    logic        level;
    logic        masked;
    logic [15:0] dest;
  } rteFields_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // latch selected pin into the output slot
    logic rewind;  // scan pointer back to pin 0
  } irdeCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic found;   // a deliverable pin exists at or above the pointer
    logic kick;    // an event that calls for a pass
  } irdeStat_t;

  function automatic rteFields_t decodeEntry(input logic [ENTRY_W-1:0] e);
    rteFields_t f;
    f.vector    = e[7:0];
    f.dlvMode   = e[DM_LSB +: 3];
    f.dstMode   = e[DMODE_BIT];
    f.remoteIrr = e[RIRR_BIT];
    f.level     = e[TRIG_BIT];
    f.masked    = e[MASK_BIT];
    f.dest      = e[DEST_LSB +: 16];
    return f;
  endfunction

  function automatic logic [31:0] msgAddrOf(input rteFields_t f);
    return MSG_BASE | (32'(f.dest) << 12) | (32'(f.dstMode) << 2);
  endfunction

  function automatic logic [31:0] msgDataOf(input rteFields_t f);
    return {16'h0, f.level, 4'h0, f.dlvMode, f.vector};
  endfunction

endpackage

// File: rtl/irq_redirect_dp.sv
module irq_redirect_dp
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS),
  localparam int PTR_W = $clog2(NUM_PINS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS-1:0]         irqIn,
  input  logic [NUM_PINS*ENTRY_W-1:0] rteIn,
  input  logic                        eoiValid,
  input  logic [7:0]                  eoiVector,
  input  irdeCtl_t                    ctl,
  output irdeStat_t                   stat,
  output logic [NUM_PINS-1:0]         rirrSet,
  output logic [NUM_PINS-1:0]         rirrClr,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData
);

  rteFields_t fld [NUM_PINS];
  logic [NUM_PINS-1:0] pinNow, pinQ, rise, edgePend, pending;
  logic [NUM_PINS-1:0] isLevel, isMasked, rirrOn, inRange, cand;
  logic [NUM_PINS-1:0] edgeSet, edgeClr, levelKick, eoiHit, eoiKick;
  logic [PTR_W-1:0]    ptr;
  logic [IDX_W-1:0]    selIdx;
  logic                found;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign fld[p] = decodeEntry(rteIn[p*ENTRY_W +: ENTRY_W]);

    // input routing: input 0 feeds pin 2, pin 0 has no source
    if (p == 0) begin : g_none
      assign pinNow[p] = 1'b0;
    end else if (p == 2) begin : g_merge
      assign pinNow[p] = irqIn[2] | irqIn[0];
    end else begin : g_direct
      assign pinNow[p] = irqIn[p];
    end

    assign isLevel[p]   = fld[p].level;
    assign isMasked[p]  = fld[p].masked;
    assign rirrOn[p]    = fld[p].remoteIrr;
    assign rise[p]      = pinNow[p] & ~pinQ[p];
    assign edgeSet[p]   = rise[p] & ~isLevel[p] & ~isMasked[p];
    assign levelKick[p] = rise[p] & isLevel[p] & ~rirrOn[p];
    assign pending[p]   = isLevel[p] ? pinQ[p] : edgePend[p];
    assign inRange[p]   = (PTR_W'(p) >= ptr);
    assign cand[p]      = pending[p] & ~isMasked[p] & ~(isLevel[p] & rirrOn[p]) & inRange[p];
    assign eoiHit[p]    = eoiValid & rirrOn[p] & (fld[p].vector == eoiVector);
    assign eoiKick[p]   = eoiHit[p] & ~isMasked[p] & pending[p];
    assign edgeClr[p]   = ctl.load & (selIdx == IDX_W'(p)) & ~isLevel[p];
    assign rirrSet[p]   = ctl.load & (selIdx == IDX_W'(p)) & isLevel[p];
    assign rirrClr[p]   = eoiHit[p];
  end

  // lowest deliverable pin at or above the scan pointer
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign stat.found = found;
  assign stat.kick  = (|edgeSet) | (|levelKick) | (|eoiKick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ     <= '0;
      edgePend <= '0;
      ptr      <= '0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      pinQ     <= pinNow;
      edgePend <= (edgePend & ~edgeClr) | edgeSet;
      if (ctl.rewind) begin
        ptr <= '0;
      end else if (ctl.load) begin
        ptr <= PTR_W'(selIdx) + PTR_W'(1);
      end
      if (ctl.load) begin
        msgAddr <= msgAddrOf(fld[selIdx]);
        msgData <= msgDataOf(fld[selIdx]);
      end
    end
  end

endmodule

// File: rtl/irq_redirect_ctl.sv
module irq_redirect_ctl
  import irq_redirect_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  irdeStat_t stat,
  input  logic      msgReady,
  output irdeCtl_t  ctl,
  output logic      msgValid
);

  logic passActive, rerun, slotFree, passEnd;

  assign slotFree   = ~msgValid | msgReady;
  assign passEnd    = passActive & ~stat.found;
  assign ctl.load   = passActive & stat.found & slotFree;
  assign ctl.rewind = passEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passActive <= 1'b0;
      rerun      <= 1'b0;
      msgValid   <= 1'b0;
    end else begin
      if (!passActive) begin
        passActive <= stat.kick;
      end else if (passEnd) begin
        passActive <= rerun | stat.kick;
      end

      if (!passActive || passEnd) begin
        rerun <= 1'b0;
      end else if (stat.kick) begin
        rerun <= 1'b1;
      end

      if (ctl.load) begin
        msgValid <= 1'b1;
      end else if (msgReady) begin
        msgValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PINS-1:0]         irqIn,
  input  logic [NUM_PINS*ENTRY_W-1:0] rteIn,
  input  logic                        eoiValid,
  input  logic [7:0]                  eoiVector,
  output logic                        msgValid,
  input  logic                        msgReady,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData,
  output logic [NUM_PINS-1:0]         rirrSet,
  output logic [NUM_PINS-1:0]         rirrClr
);

  irdeCtl_t  ctl;
  irdeStat_t stat;

  irq_redirect_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .rteIn     (rteIn),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .ctl       (ctl),
    .stat      (stat),
    .rirrSet   (rirrSet),
    .rirrClr   (rirrClr),
    .msgAddr   (msgAddr),
    .msgData   (msgData)
  );

  irq_redirect_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .msgReady (msgReady),
    .ctl      (ctl),
    .msgValid (msgValid)
  );

endmodule

// File: rtl/irq_redirect_engine_chk.sv
module irq_redirect_engine_chk
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PINS*ENTRY_W-1:0] rteIn,
  input logic                        eoiValid,
  input logic                        msgValid,
  input logic                        msgReady,
  input logic [31:0]                 msgAddr,
  input logic [31:0]                 msgData,
  input logic [NUM_PINS-1:0]         rirrSet,
  input logic [NUM_PINS-1:0]         rirrClr
);

  logic [NUM_PINS-1:0] levelMask, rirrMask;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_view
    assign levelMask[p] = rteIn[p*ENTRY_W + TRIG_BIT];
    assign rirrMask[p]  = rteIn[p*ENTRY_W + RIRR_BIT];
  end

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R10

  AST_MSG_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[31:28] == 4'hF && msgAddr[1:0] == 2'b00 && msgData[31:16] == 16'h0 && msgData[14:11] == 4'h0)); // R3

  AST_SET_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((rirrSet & ~(levelMask & ~rirrMask)) == '0)); // R7

  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rirrSet)); // R7

  AST_SET_THEN_MSG: assert property (@(posedge clk) disable iff (!rstN)
    (|rirrSet) |=> msgValid); // R7

  AST_CLR_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rstN)
    (|rirrClr) |-> (eoiValid && ((rirrClr & ~rirrMask) == '0))); // R8

endmodule

bind irq_redirect_engine irq_redirect_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rteIn    (rteIn),
  .eoiValid (eoiValid),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgAddr  (msgAddr),
  .msgData  (msgData),
  .rirrSet  (rirrSet),
  .rirrClr  (rirrClr)
);

// File: tb/test_irq_redirect_engine.sv
`timescale 1ns/1ps
module test_irq_redirect_engine;

  localparam int NP = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NP-1:0]    irq = '0;
  logic [NP*64-1:0] rteFlat;
  logic             eoiValid = 1'b0;
  logic [7:0]       eoiVector = '0;
  logic             msgValid, msgReady = 1'b1;
  logic [31:0]      msgAddr, msgData;
  logic [NP-1:0]    rirrSet, rirrClr;

  logic [63:0] cfg [NP];
  logic [NP-1:0] rirrQ;

  int nChecks = 0;
  int nFail = 0;
  int nGot = 0;
  logic [31:0] gotAddr [0:511];
  logic [31:0] gotData [0:511];

  always #2 clk = ~clk;

  irq_redirect_engine #(.NUM_PINS(NP)) i_irq_redirect_engine (
    .clk(clk), .rstN(rstN), .irqIn(irq), .rteIn(rteFlat),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData),
    .rirrSet(rirrSet), .rirrClr(rirrClr)
  );

  // register-file model: remote-IRR bit driven by the strobes
  always @(posedge clk) begin
    if (!rstN) rirrQ <= '0;
    else rirrQ <= (rirrQ | rirrSet) & ~rirrClr;
  end

  always_comb begin
    for (int p = 0; p < NP; p++)
      rteFlat[p*64 +: 64] = {cfg[p][63:15], rirrQ[p], cfg[p][13:0]};
  end

  // message monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      gotAddr[nGot] <= msgAddr;
      gotData[nGot] <= msgData;
      nGot <= nGot + 1;
    end
  end

  function automatic logic [7:0] vecOf(input int p);  return 8'(32'h20 + p * 5); endfunction
  function automatic logic [2:0] dmOf(input int p);   return 3'(p % 8); endfunction
  function automatic logic dmodeOf(input int p);      return 1'(p % 2); endfunction
  function automatic logic [15:0] destOf(input int p); return 16'(p * 32'h0911); endfunction

  function automatic logic [31:0] expAddr(input int p);
    return 32'hFEE0_0000 | (32'(destOf(p)) << 12) | (32'(dmodeOf(p)) << 2);
  endfunction

  function automatic logic [31:0] expData(input int p, input logic lvl);
    return 32'(vecOf(p)) | (32'(dmOf(p)) << 8) | (32'(lvl) << 15);
  endfunction

  function automatic logic [63:0] mkEntry(input int p, input logic lvl, input logic msk);
    logic [63:0] e = '0;
    e[7:0]   = vecOf(p);
    e[10:8]  = dmOf(p);
    e[11]    = dmodeOf(p);
    e[15]    = lvl;
    e[16]    = msk;
    e[40]    = 1'b1;
    e[63:48] = destOf(p);
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    @(posedge clk); #1 irq = irq | m;
    @(posedge clk); #1 irq = irq & ~m;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(posedge clk); #1 eoiValid = 1'b1; eoiVector = v;
    @(posedge clk); #1 eoiValid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int base;
    for (int p = 0; p < NP; p++) cfg[p] = mkEntry(p, 1'b0, 1'b0);

    // R1: reset state
    cyc(5);
    @(negedge clk);
    chk("R1 valid", 32'(msgValid), 32'd0);
    chk("R1 strobes", 32'(rirrSet | rirrClr), 32'd0);
    @(posedge clk); #1 rstN = 1'b1;
    cyc(4);
    chk("R1 idle", 32'(nGot), 32'd0);

    // R2/R3 sweep over every routable pin
    for (int p = 1; p < NP; p++) begin
      base = nGot;
      pulse(NP'(1) << p);
      cyc(10);
      chk("R2 one message", 32'(nGot - base), 32'd1);
      chk("R3 address", gotAddr[base], expAddr(p));
      chk("R3 data", gotData[base], expData(p, 1'b0));
    end

    // R4: input 0 lands on pin 2
    base = nGot;
    pulse(NP'(1));
    cyc(10);
    chk("R4 count", 32'(nGot - base), 32'd1);
    chk("R4 address", gotAddr[base], expAddr(2));
    chk("R4 data", gotData[base], expData(2, 1'b0));

    // R5: masked edge dropped
    base = nGot;
    cfg[6] = mkEntry(6, 1'b0, 1'b1);
    pulse(NP'(1) << 6);
    cyc(8);
    chk("R5 masked none", 32'(nGot - base), 32'd0);
    cfg[6] = mkEntry(6, 1'b0, 1'b0);
    cyc(1);
    pulse(NP'(1) << 9);
    cyc(10);
    chk("R5 only kick pin", 32'(nGot - base), 32'd1);
    chk("R5 kick data", gotData[base], expData(9, 1'b0));

    // R10/R6: stall, then mask a pin ahead of the scan
    base = nGot;
    @(posedge clk); #1 msgReady = 1'b0;
    pulse((NP'(1) << 3) | (NP'(1) << 5) | (NP'(1) << 7));
    cyc(6);
    chk("R10 valid held", 32'(msgValid), 32'd1);
    chk("R10 data held", msgData, expData(3, 1'b0));
    cfg[5] = mkEntry(5, 1'b0, 1'b1);
    cyc(4);
    chk("R10 data still", msgData, expData(3, 1'b0));
    chk("R10 no accept", 32'(nGot - base), 32'd0);
    msgReady = 1'b1;
    cyc(10);
    chk("R6 count", 32'(nGot - base), 32'd2);
    chk("R6 first", gotData[base], expData(3, 1'b0));
    chk("R6 second", gotData[base+1], expData(7, 1'b0));
    base = nGot;
    cfg[5] = mkEntry(5, 1'b0, 1'b0);
    cyc(1);
    pulse(NP'(1) << 11);
    cyc(10);
    chk("R6 kept pending count", 32'(nGot - base), 32'd2);
    chk("R6 kept pending first", gotData[base], expData(5, 1'b0));
    chk("R6 kept pending second", gotData[base+1], expData(11, 1'b0));

    // R11: same-cycle assertions, ascending order
    base = nGot;
    pulse((NP'(1) << 12) | (NP'(1) << 4) | (NP'(1) << 20));
    cyc(12);
    chk("R11 count", 32'(nGot - base), 32'd3);
    chk("R11 first", gotData[base], expData(4, 1'b0));
    chk("R11 second", gotData[base+1], expData(12, 1'b0));
    chk("R11 third", gotData[base+2], expData(20, 1'b0));

    // R12: request below the scan position during a stalled pass
    base = nGot;
    @(posedge clk); #1 msgReady = 1'b0;
    pulse((NP'(1) << 10) | (NP'(1) << 15));
    cyc(4);
    pulse(NP'(1) << 4);
    cyc(3);
    msgReady = 1'b1;
    cyc(12);
    chk("R12 count", 32'(nGot - base), 32'd3);
    chk("R12 first", gotData[base], expData(10, 1'b0));
    chk("R12 second", gotData[base+1], expData(15, 1'b0));
    chk("R12 follow-up", gotData[base+2], expData(4, 1'b0));

    // R7: level pin 8
    cfg[8] = mkEntry(8, 1'b1, 1'b0);
    base = nGot;
    @(posedge clk); #1 irq[8] = 1'b1;
    cyc(10);
    chk("R7 first delivery", 32'(nGot - base), 32'd1);
    chk("R7 level data", gotData[base], expData(8, 1'b1));
    chk("R7 remote-IRR set", 32'(rirrQ[8]), 32'd1);
    base = nGot;
    irq[8] = 1'b0;
    cyc(2);
    irq[8] = 1'b1;
    cyc(10);
    chk("R7 coalesced", 32'(nGot - base), 32'd0);

    // R8: non-matching then matching end-of-interrupt
    eoi(vecOf(8) - 8'd1);
    cyc(8);
    chk("R8 mismatch no msg", 32'(nGot - base), 32'd0);
    chk("R8 mismatch keeps bit", 32'(rirrQ[8]), 32'd1);
    eoi(vecOf(8));
    cyc(10);
    chk("R8 redelivered", 32'(nGot - base), 32'd1);
    chk("R8 redelivered data", gotData[base], expData(8, 1'b1));
    chk("R8 bit set again", 32'(rirrQ[8]), 32'd1);

    // R9: input dropped before end-of-interrupt
    base = nGot;
    irq[8] = 1'b0;
    cyc(3);
    eoi(vecOf(8));
    cyc(8);
    chk("R9 cleared", 32'(rirrQ[8]), 32'd0);
    chk("R9 no msg", 32'(nGot - base), 32'd0);
    irq[8] = 1'b1;
    cyc(10);
    chk("R9 new assertion", 32'(nGot - base), 32'd1);
    chk("R9 new data", gotData[base], expData(8, 1'b1));
    irq[8] = 1'b0;
    cyc(4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule